// File: doc/BRIEF.md
# Multiplexed Converter Sequence Controller

This block drives the digital side of a multiplexed successive-approximation converter. It holds a list of up to sixteen channel numbers and works through them in order. For each entry it selects the input channel and holds a sample phase whose length comes from that channel's sample-time code. It then holds a conversion phase whose length comes from the resolution setting. At the end of the conversion phase it takes the raw value from the converter, trims it to the chosen resolution, and places it either at bit 0 or against bit 15. It writes this value to the data output and raises the end-of-conversion flag.

A pass can be started by a software start strobe or by a chosen edge of an external trigger line. A pass converts one entry, or the whole list when scanning is on. In continuous mode the pass repeats with no gap. Both phases are counted in converter-clock ticks, and these ticks come from the bus clock through a selectable even divider. The converter itself is outside the block: the block presents a channel select and phase strobes, and reads back a 12-bit result port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The converter tick period is 2, 4, 6 or 8 bus cycles for `cfg_clk_div` = 0, 1, 2, 3. The divider restarts when a pass starts.
- R2: The conversion phase lasts 15, 13, 11 or 9 ticks for `cfg_res` = 0, 1, 2, 3. The result keeps the top 12, 10, 8 or 6 bits of `ana_result`.
- R3: The sample phase lasts 3, 15, 28, 56, 84, 112, 144 or 480 ticks for sample code 0 to 7. Channel c reads its code from `cfg_smp_codes[3c+2:3c]`.
- R4: Slot s holds its channel in `cfg_slots[5s+4:5s]`. With `cfg_scan`=1 a pass converts slots 0 to `cfg_seq_len` in ascending order. With `cfg_scan`=0 it converts slot 0 only.
- R5: No pass starts while `cfg_enable` is 0. Clearing `cfg_enable` returns the block to idle.
- R6: `cfg_trig_mode` selects the external start: 0 is off, 1 is a rising edge, 2 a falling edge, 3 either edge. An edge that does not match the mode starts nothing.
- R7: With `cfg_cont`=0 the block goes idle after one pass. With `cfg_cont`=1 slot 0 follows the last slot at once. The bit is sampled at the end of each pass.
- R8: With `cfg_align`=0 the trimmed result sits at bit 0 with zeros above it. With `cfg_align`=1 its MSB is bit 15 and the bits below it are zero.
- R9: `eoc` and `data_out` update at the same edge and `res_strobe` pulses for one cycle. A `data_rd` strobe, or `flag_wr` with `flag_wdata`=0, clears `eoc`. `flag_wr` with `flag_wdata`=1 leaves it unchanged.
- R10: A software start or a trigger edge that arrives while a pass is running is ignored.
- R11: After reset the block is idle, with `eoc`=0, `data_out`=0, `res_strobe`=0 and both phase strobes low.
- R12: `ana_sel` carries the current slot's channel and stays stable through a sample phase. `ana_sample` and `ana_convert` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Converter enable |
| cfg_clk_div | input | 2 | Tick divider select |
| cfg_res | input | 2 | Resolution select |
| cfg_align | input | 1 | 1 = left-justified result |
| cfg_cont | input | 1 | 1 = repeat passes |
| cfg_scan | input | 1 | 1 = convert whole slot list |
| cfg_trig_mode | input | 2 | External trigger edge select |
| cfg_seq_len | input | 4 | Index of last slot in a scan |
| cfg_slots | input | 80 | Channel number per slot, 5 bits each |
| cfg_smp_codes | input | 57 | Sample-time code per channel, 3 bits each |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | Asynchronous external trigger line |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value (0 clears) |
| data_rd | input | 1 | Data read strobe, clears eoc |
| ana_result | input | 12 | Raw converter result |
| ana_sel | output | 5 | Selected input channel |
| ana_sample | output | 1 | Sample phase active |
| ana_convert | output | 1 | Conversion phase active |
| data_out | output | 16 | Formatted result |
| eoc | output | 1 | End-of-conversion flag |
| res_strobe | output | 1 | One-cycle pulse per new result |
| busy | output | 1 | Pass in progress |

## Verification
Call E0 the clock edge that accepts a start. This is the edge that samples `sw_start`, or the third edge after the trigger line changes, because the trigger passes through two synchronizer flops and an edge register. Each result is then due one tick-count times tick-period after the previous one (or after E0), where the tick count is the sample length plus the conversion length and the tick period is 2×(divider+1) bus cycles. The bench adds these durations into absolute cycle numbers when it queues the expected results. The monitor pops an entry on each `res_strobe` and compares both the value and the cycle number. Stimuli that must be ignored are followed by a wait longer than one conversion, then a check of `busy`, and any result that arrives with an empty queue counts as a failure.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 5;
  localparam int SMP_W  = 3;
  localparam int LEN_W  = 4;
  localparam int NUM_SLOT = 2 ** LEN_W;
  localparam int CNT_W  = 9;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  function automatic logic [CNT_W-1:0] smp_ticks(input logic [SMP_W-1:0] code);
    logic [CNT_W-1:0] t;
    case (code)
      3'd0: t = 9'd3;
      3'd1: t = 9'd15;
      3'd2: t = 9'd28;
      3'd3: t = 9'd56;
      3'd4: t = 9'd84;
      3'd5: t = 9'd112;
      3'd6: t = 9'd144;
      default: t = 9'd480;
    endcase
    return t;
  endfunction

  function automatic logic [CNT_W-1:0] conv_ticks(input logic [1:0] res);
    return 9'd15 - {6'd0, res, 1'b0};
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int MAX_P = 2 * (2 ** DIV_W);
  localparam int PC_W  = $clog2(MAX_P);

  logic [PC_W-1:0] pc_q, pc_n;
  logic [PC_W-1:0] last_pc;

  assign last_pc = PC_W'({div_sel, 1'b1});
  assign tick    = !clr && (pc_q == last_pc);

  always_comb begin
    if (clr || pc_q >= last_pc) pc_n = '0;
    else                        pc_n = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_n;
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  input  logic [1:0] trig_mode,
  input  logic       sw_start,
  input  logic       ext_trig,
  input  logic       busy,
  output logic       start
);
  logic sync1_q, sync2_q, prev_q;
  logic rise, fall, trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= ext_trig;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q && !prev_q;
  assign fall = !sync2_q && prev_q;

  always_comb begin
    case (trig_mode)
      2'd1:    trig_hit = rise;
      2'd2:    trig_hit = fall;
      2'd3:    trig_hit = rise || fall;
      default: trig_hit = 1'b0;
    endcase
  end

  assign start = cfg_enable && !busy && (sw_start || trig_hit);

  assert_start_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cfg_enable);
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        res,
  input  logic              align,
  input  logic [RES_W-1:0]  raw,
  output logic [DATA_W-1:0] fmt
);
  localparam int PAD = DATA_W - RES_W;

  logic [4:0]        shift;
  logic [DATA_W-1:0] trimmed;
  logic [DATA_W-1:0] left;

  assign shift   = {2'd0, res, 1'b0};
  assign trimmed = DATA_W'(raw >> shift);
  assign left    = (trimmed << shift) << PAD;
  assign fmt     = align ? left : trimmed;

  assert_right_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !align |-> ((fmt >> (5'(RES_W) - shift)) == '0));
  assert_left_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    align |-> ((fmt & ((DATA_W'(1) << (shift + 5'(PAD))) - 1'b1)) == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 19,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_enable,
  input  logic [1:0]                 cfg_clk_div,
  input  logic [1:0]                 cfg_res,
  input  logic                       cfg_align,
  input  logic                       cfg_cont,
  input  logic                       cfg_scan,
  input  logic [1:0]                 cfg_trig_mode,
  input  logic [LEN_W-1:0]           cfg_seq_len,
  input  logic [NUM_SLOT*CH_W-1:0]   cfg_slots,
  input  logic [NUM_CH*SMP_W-1:0]    cfg_smp_codes,
  input  logic                       sw_start,
  input  logic                       ext_trig,
  input  logic                       flag_wr,
  input  logic                       flag_wdata,
  input  logic                       data_rd,
  input  logic [RES_W-1:0]           ana_result,
  output logic [CH_W-1:0]            ana_sel,
  output logic                       ana_sample,
  output logic                       ana_convert,
  output logic [DATA_W-1:0]          data_out,
  output logic                       eoc,
  output logic                       res_strobe,
  output logic                       busy
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // configuration unpacking
  logic [CH_W-1:0]  slot_ch  [NUM_SLOT];
  logic [SMP_W-1:0] smp_code [NUM_CH];

  for (genvar gs = 0; gs < NUM_SLOT; gs++) begin : g_slot
    assign slot_ch[gs] = cfg_slots[gs*CH_W +: CH_W];
  end
  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    assign smp_code[gc] = cfg_smp_codes[gc*SMP_W +: SMP_W];
  end

  // state
  seq_state_t        state_q, state_n;
  logic [LEN_W-1:0]  slot_q, slot_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] data_q;
  logic              eoc_q, eoc_n;
  logic              strobe_q;

  logic              start, tick, div_clr, done;
  logic [CH_W-1:0]   cur_ch;
  logic [SMP_W-1:0]  cur_code;
  logic [CNT_W-1:0]  smp_len, conv_len;
  logic [LEN_W-1:0]  last_slot;
  logic [DATA_W-1:0] fmt;

  assign busy      = (state_q != ST_IDLE);
  assign cur_ch    = slot_ch[slot_q];
  assign last_slot = cfg_scan ? cfg_seq_len : '0;
  assign smp_len   = smp_ticks(cur_code);
  assign conv_len  = conv_ticks(cfg_res);

  always_comb begin
    cur_code = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cur_ch == CH_W'(i)) cur_code = smp_code[i];
    end
  end

  adc_clk_div #(.DIV_W(2)) u_div (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (div_clr),
    .div_sel (cfg_clk_div),
    .tick    (tick)
  );

  adc_start_ctrl u_start (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .cfg_enable (cfg_enable),
    .trig_mode  (cfg_trig_mode),
    .sw_start   (sw_start),
    .ext_trig   (ext_trig),
    .busy       (busy),
    .start      (start)
  );

  adc_result_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .res   (cfg_res),
    .align (cfg_align),
    .raw   (ana_result),
    .fmt   (fmt)
  );

  // sequencing next-state
  always_comb begin
    state_n = state_q;
    slot_n  = slot_q;
    cnt_n   = cnt_q;
    done    = 1'b0;
    div_clr = 1'b0;
    if (!cfg_enable) begin
      state_n = ST_IDLE;
      slot_n  = '0;
      cnt_n   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_n = ST_SAMPLE;
            slot_n  = '0;
            cnt_n   = '0;
            div_clr = 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (tick) begin
            if (cnt_q >= smp_len - 1'b1) begin
              state_n = ST_CONV;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick) begin
            if (cnt_q >= conv_len - 1'b1) begin
              done  = 1'b1;
              cnt_n = '0;
              if (slot_q >= last_slot) begin
                slot_n  = '0;
                state_n = cfg_cont ? ST_SAMPLE : ST_IDLE;
              end else begin
                slot_n  = slot_q + 1'b1;
                state_n = ST_SAMPLE;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // flag next-state: a new result wins over a clear in the same cycle
  always_comb begin
    if (done)                              eoc_n = 1'b1;
    else if (data_rd || (flag_wr && !flag_wdata)) eoc_n = 1'b0;
    else                                   eoc_n = eoc_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_IDLE;
      slot_q   <= '0;
      cnt_q    <= '0;
      eoc_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      slot_q   <= slot_n;
      cnt_q    <= cnt_n;
      eoc_q    <= eoc_n;
      strobe_q <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  data_q <= '0;
    else if (done) data_q <= fmt;
  end

  assign ana_sel     = cur_ch;
  assign ana_sample  = (state_q == ST_SAMPLE);
  assign ana_convert = (state_q == ST_CONV);
  assign data_out    = data_q;
  assign eoc         = eoc_q;
  assign res_strobe  = strobe_q;

  assert_eoc_with_data_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(eoc_q) |-> strobe_q);
  assert_done_after_conv_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    strobe_q |-> $past(ana_convert));
  assert_sel_hold_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ana_sample && $past(ana_sample)) |-> $stable(ana_sel));
  assert_phase_excl_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({ana_sample, ana_convert}));
  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_enable |=> !busy);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 19;

  typedef struct {
    logic [15:0] data;
    int          cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_align, cfg_cont, cfg_scan;
  logic [1:0]  cfg_clk_div, cfg_res, cfg_trig_mode;
  logic [3:0]  cfg_seq_len;
  logic [79:0] cfg_slots;
  logic [56:0] cfg_smp_codes;
  logic        sw_start, ext_trig, flag_wr, flag_wdata, data_rd;
  logic [11:0] ana_result;
  logic [4:0]  ana_sel;
  logic        ana_sample, ana_convert, eoc, res_strobe, busy;
  logic [15:0] data_out;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // stand-in converter: value is a function of the selected channel
  assign ana_result = 12'((32'(ana_sel) * 97) ^ 32'hA5C);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clk_div(cfg_clk_div),
    .cfg_res(cfg_res), .cfg_align(cfg_align), .cfg_cont(cfg_cont), .cfg_scan(cfg_scan),
    .cfg_trig_mode(cfg_trig_mode), .cfg_seq_len(cfg_seq_len), .cfg_slots(cfg_slots),
    .cfg_smp_codes(cfg_smp_codes), .sw_start(sw_start), .ext_trig(ext_trig),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .data_rd(data_rd),
    .ana_result(ana_result), .ana_sel(ana_sel), .ana_sample(ana_sample),
    .ana_convert(ana_convert), .data_out(data_out), .eoc(eoc),
    .res_strobe(res_strobe), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int smp_of(input int code);
    case (code)
      0: return 3;   1: return 15;  2: return 28;  3: return 56;
      4: return 84;  5: return 112; 6: return 144; default: return 480;
    endcase
  endfunction

  function automatic logic [15:0] model(input int ch, input int res, input bit align);
    logic [11:0] v;
    logic [15:0] r;
    v = 12'((ch * 97) ^ 32'hA5C);
    r = 16'(v >> (2 * res));
    return align ? 16'((r << (2 * res)) << 4) : r;
  endfunction

  function automatic int code_of(input int ch);
    return int'(cfg_smp_codes[ch*3 +: 3]);
  endfunction

  // driver side: queue one expected conversion, advancing the time cursor t
  task automatic push_exp(input int ch, inout int t, input string tag);
    t += (smp_of(code_of(ch)) + 15 - 2 * int'(cfg_res)) * 2 * (int'(cfg_clk_div) + 1);
    q.push_back('{model(ch, int'(cfg_res), cfg_align), t, tag});
  endtask

  task automatic sw_go(output int e0);
    @(negedge clk);
    sw_start = 1'b1;
    e0 = cyc + 1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic drain;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_slot(input int s, input int ch);
    cfg_slots[s*5 +: 5] = 5'(ch);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n && res_strobe) begin
      if (q.size() == 0) begin
        check(1'b0, "R10/R5/R7 unexpected result", int'(data_out), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(data_out == e.data, {e.tag, " data"}, int'(data_out), int'(e.data));
        check(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
        check(eoc == 1'b1, "R9 eoc with data", int'(eoc), 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int t;
    int m;
    rst_n = 1'b0;
    cfg_enable = 0; cfg_clk_div = 0; cfg_res = 0; cfg_align = 0; cfg_cont = 0;
    cfg_scan = 0; cfg_trig_mode = 0; cfg_seq_len = 0; cfg_slots = '0;
    cfg_smp_codes = '0; sw_start = 0; ext_trig = 0; flag_wr = 0; flag_wdata = 0;
    data_rd = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check(eoc == 0 && busy == 0, "R11 reset flags", int'({eoc, busy}), 0);
    check(data_out == 0, "R11 reset data", int'(data_out), 0);
    check(!ana_sample && !ana_convert && !res_strobe, "R11 reset strobes",
          int'({ana_sample, ana_convert, res_strobe}), 0);

    // R5 start ignored while disabled
    set_slot(0, 3);
    sw_go(t);
    repeat (100) @(negedge clk);
    check(busy == 0, "R5 disabled start", int'(busy), 0);

    // R1/R2/R3 12-bit, div 2, code 0, right aligned
    cfg_enable = 1;
    sw_go(t);
    push_exp(3, t, "R1/R2/R3 12bit");
    drain();
    check(eoc == 1, "R9 eoc held", int'(eoc), 1);
    @(negedge clk); flag_wr = 1; flag_wdata = 1;
    @(negedge clk); flag_wr = 0;
    check(eoc == 1, "R9 write one keeps", int'(eoc), 1);
    @(negedge clk); flag_wr = 1; flag_wdata = 0;
    @(negedge clk); flag_wr = 0;
    check(eoc == 0, "R9 write zero clears", int'(eoc), 0);

    // R8 left aligned 6-bit, div 8, code 1
    cfg_res = 3; cfg_align = 1; cfg_clk_div = 3;
    set_slot(0, 5); cfg_smp_codes[5*3 +: 3] = 3'd1;
    sw_go(t);
    push_exp(5, t, "R8/R1/R2 left 6bit");
    drain();

    // R4 scan of three slots; R10 trigger during run ignored
    cfg_res = 1; cfg_align = 0; cfg_clk_div = 1; cfg_scan = 1; cfg_seq_len = 2;
    set_slot(0, 7); set_slot(1, 2); set_slot(2, 18);
    cfg_smp_codes[7*3 +: 3] = 3'd2; cfg_smp_codes[2*3 +: 3] = 3'd7;
    cfg_smp_codes[18*3 +: 3] = 3'd3;
    cfg_trig_mode = 2'd1;
    sw_go(t);
    push_exp(7, t, "R4/R3 slot0");
    push_exp(2, t, "R4/R3 slot1");
    push_exp(18, t, "R4/R3 slot2");
    repeat (60) @(negedge clk);
    check(ana_sel == 5'd7 && ana_sample, "R12 sel slot0", int'(ana_sel), 7);
    ext_trig = 1;
    repeat (20) @(negedge clk);
    sw_start = 1; @(negedge clk); sw_start = 0;
    drain();
    repeat (60) @(negedge clk);
    check(busy == 0, "R10 no restart after busy edge", int'(busy), 0);
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    check(eoc == 0, "R9 read clears", int'(eoc), 0);

    // R6 falling edge under rising mode does nothing
    ext_trig = 0;
    repeat (60) @(negedge clk);
    check(busy == 0, "R6 wrong edge", int'(busy), 0);

    // R4 scan off converts slot 0 only; R6 falling-edge start
    cfg_scan = 0; cfg_trig_mode = 2'd2; cfg_clk_div = 0; cfg_res = 2;
    @(negedge clk); ext_trig = 1;
    repeat (30) @(negedge clk);
    check(busy == 0, "R6 rise under falling mode", int'(busy), 0);
    m = cyc; ext_trig = 0;
    t = m + 3;
    push_exp(7, t, "R6/R4 falling start slot0 only");
    drain();
    repeat (60) @(negedge clk);
    check(busy == 0, "R4 single slot pass", int'(busy), 0);

    // R6 mode 0 ignores edges
    cfg_trig_mode = 2'd0;
    @(negedge clk); ext_trig = 1;
    repeat (10) @(negedge clk); ext_trig = 0;
    repeat (30) @(negedge clk);
    check(busy == 0, "R6 trigger off", int'(busy), 0);

    // R7 continuous: two passes of two slots, then stop
    cfg_trig_mode = 2'd3; cfg_scan = 1; cfg_seq_len = 1; cfg_cont = 1; cfg_res = 3;
    set_slot(0, 1); set_slot(1, 4);
    @(negedge clk); m = cyc; ext_trig = 1;
    t = m + 3;
    push_exp(1, t, "R7/R6 pass1 s0");
    push_exp(4, t, "R7 pass1 s1");
    push_exp(1, t, "R7 pass2 s0");
    push_exp(4, t, "R7 pass2 s1");
    while (q.size() > 1) @(negedge clk);
    cfg_cont = 0;
    drain();
    repeat (60) @(negedge clk);
    check(busy == 0, "R7 stop after pass", int'(busy), 0);

    // R5 clearing enable aborts a pass
    cfg_seq_len = 0;
    sw_go(t);
    repeat (10) @(negedge clk);
    check(busy == 1, "R5 running", int'(busy), 1);
    cfg_enable = 0;
    repeat (2) @(negedge clk);
    check(busy == 0, "R5 disable to idle", int'(busy), 0);
    repeat (60) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule